// File: doc/BRIEF.md
# Instruction Fetch Window Cache

This block feeds opcode bytes to an 8-bit-fetch coprocessor. It holds a 512-byte copy of program memory. The copy covers a sliding window that starts at a base address taken from the `base_i` input. Each fetch forms an offset by subtracting the base from the 16-bit fetch address, modulo 2^16. An offset below 512 selects one of 32 lines of 16 bytes. Each line carries a single valid bit. When a fetch lands on an invalid line, the block reads the whole line from an external byte-wide bus over a request/acknowledge handshake. It then marks the line valid and returns the requested byte.

A fetch whose offset falls outside the window goes straight to the bus. The bank number decides whether this is a ROM read or a RAM read. A one-cycle synchronisation strobe for that memory comes first, then the bus read.

The block owns the program counter and a one-byte prefetch register, which holds the next opcode. An advance operation increments the counter before the refetch. A peek operation refetches at the current counter. A host port reads and writes cache bytes relative to the base. A flush input invalidates every line. The `cost_o` output accumulates the cycle cost of all fetches, so hit and miss timing can be observed.

Top module: `ifetch_window_cache`

## Requirements
- R1: A fetch is served from the cache when (target address − `base_i`) mod 2^16 is below 512. Otherwise it is a direct bus read. Only a direct read pulses `rom_sync_o` or `ram_sync_o`.
- R2: A fetch on an invalid line issues 16 bus reads at consecutive addresses. They start at {bank, (base + (offset AND 0x1F0)) AND 0xFFF0}. Byte n of the line is stored from the n-th read. The requested byte is the one at line position offset[3:0].
- R3: A fetch on a valid line issues no bus read and adds CACHE_COST (default 1) to `cost_o`.
- R4: Every acknowledged bus byte adds MEM_COST (default 5) to `cost_o`. `cost_o` changes at no other time except the hit charge of R3.
- R5: For a direct read, `rom_sync_o` pulses for one cycle when bank ≤ 0x5F. Otherwise `ram_sync_o` pulses. After the pulse comes exactly one bus read at address {bank, target}.
- R6: A flush with no fill in progress clears all valid bits and leaves the data bytes intact.
- R7: A flush raised during a line fill takes effect when the fill ends. The filled line is left invalid, and the requested byte is still delivered.
- R8: Host accesses use index (`hst_addr_i` + base) AND 511. Read data appears on `hst_rdata_o` one cycle later. A write to line position 15 sets that line valid. Host writes made while `busy_o` is high are ignored.
- R9: Reset clears all 512 data bytes, every valid bit, the counter, the prefetch byte, the modified flag and `cost_o`.
- R10: When a fetch is accepted, `op_byte_o` takes the held prefetch byte. An advance (`op_adv_i`=1) sets the counter to counter+1. A peek (`op_adv_i`=0) keeps it. The prefetch register is then reloaded from the byte at the new counter.
- R11: `pc_load_i` sets the counter and raises `pc_mod_o`. It takes effect only when `busy_o` and `op_req_i` are both low. An accepted fetch clears `pc_mod_o`.
- R12: A fetch is accepted only when `busy_o` is low. `busy_o` stays high until the fetch completes. `op_done_o` is a one-cycle pulse in the cycle the new prefetch byte is in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_i | input | 16 | Cache window base address |
| bank_i | input | 8 | Program bank for fetches |
| op_req_i | input | 1 | Fetch request |
| op_adv_i | input | 1 | 1 = advance, 0 = peek |
| pc_load_i | input | 1 | Load program counter |
| pc_load_val_i | input | 16 | Value to load |
| flush_i | input | 1 | Invalidate all lines |
| busy_o | output | 1 | Fetch in progress |
| op_done_o | output | 1 | Fetch completed pulse |
| op_byte_o | output | 8 | Opcode byte returned by the last accepted fetch |
| pc_o | output | 16 | Program counter |
| pc_mod_o | output | 1 | Counter loaded since last fetch |
| cost_o | output | 32 | Accumulated cycle cost |
| bus_req_o | output | 1 | Bus read request |
| bus_addr_o | output | 24 | Bus byte address {bank, address} |
| bus_ack_i | input | 1 | Bus acknowledge; data valid this cycle |
| bus_rdata_i | input | 8 | Bus read data |
| rom_sync_o | output | 1 | ROM synchronisation strobe |
| ram_sync_o | output | 1 | RAM synchronisation strobe |
| hst_addr_i | input | 9 | Host byte address, relative to base |
| hst_we_i | input | 1 | Host write enable |
| hst_wdata_i | input | 8 | Host write data |
| hst_rdata_o | output | 8 | Host read data, one cycle latency |

## Verification
Some properties are checked by assertions on every cycle:
- the counter and flag stay frozen while busy;
- a fetch clears the modified flag;
- the cost counter steps only by the hit or per-byte charge;
- a strobe appears exactly when a fetch lands outside the window, and a bus request follows it;
- done pulses last a single cycle.

Other properties need the directed scenarios, because they depend on data and address history:
- the aligned fill source address, including an unaligned base;
- the byte delivered from a partly used line;
- the survival of data after a flush;
- the deferred invalidation of a line filled under a flush;
- a host-written line turning valid;
- host writes dropped during a fill.

// File: rtl/ifc_pkg.sv
// Package: shared types for the instruction fetch window cache.
// Assumes: nothing beyond IEEE 1800-2017.
package ifc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_READ   = 3'd1,
        ST_FILL   = 3'd2,
        ST_SYNC   = 3'd3,
        ST_DIRECT = 3'd4
    } fetch_state_t;
endpackage

// File: rtl/ifc_data_store.sv
// Module: byte storage for the cache window.
// Offers one write port, one combinational fetch read and one registered host read.
// Assumes: the caller never needs read-during-write forwarding on the host read.
module ifc_data_store #(
    parameter int DEPTH = 512,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    input  logic [IDX_W-1:0] hrd_idx,
    output logic [7:0]       hrd_data
);
    logic [7:0] mem_q [DEPTH];

    // Clear every byte on reset; otherwise take the single write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
        end else if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    // Register the host read data.
    always_ff @(posedge clk) begin
        if (!rst_n) hrd_data <= 8'h00;
        else        hrd_data <= mem_q[hrd_idx];
    end

    // Combinational read for the fetch path.
    always_comb rd_data = mem_q[rd_idx];
endmodule

// File: rtl/ifc_valid_table.sv
// Module: one valid bit for each cache line.
// A clear of all bits wins over a set that arrives in the same cycle.
// Assumes: at most one set request per cycle.
module ifc_valid_table #(
    parameter int NUM_LINES = 32,
    parameter int LINE_W    = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic              set_en,
    input  logic [LINE_W-1:0] set_line,
    input  logic [LINE_W-1:0] look_line,
    output logic              look_valid
);
    logic [NUM_LINES-1:0] valid_q;

    // Update the valid bits: reset and flush clear, fill or host sets.
    always_ff @(posedge clk) begin
        if (!rst_n)      valid_q <= '0;
        else if (clr_all) valid_q <= '0;
        else if (set_en)  valid_q[set_line] <= 1'b1;
    end

    // Look up one line for the hit test.
    always_comb look_valid = valid_q[look_line];
endmodule

// File: rtl/ifc_fetch_ctrl.sv
// Module: fetch sequencer for the window cache.
// Owns the program counter, the prefetch byte and the cost counter.
// Decides hit, line fill or direct read, and drives the external bus.
// Assumes: bus_ack_i is sampled with bus_req_o high and carries valid data in that cycle.
module ifc_fetch_ctrl
    import ifc_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int BANK_W     = 8,
    parameter int LINE_BYTES = 16,
    parameter int WIN_BYTES  = 512,
    parameter int COST_W     = 32,
    parameter int MEM_COST   = 5,
    parameter int CACHE_COST = 1,
    parameter logic [BANK_W-1:0] ROM_LAST_BANK = 8'h5F,
    localparam int OFS_W  = $clog2(LINE_BYTES),
    localparam int IDX_W  = $clog2(WIN_BYTES),
    localparam int LINE_W = IDX_W - OFS_W,
    localparam int BUS_W  = BANK_W + ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic              op_req_i,
    input  logic              op_adv_i,
    input  logic              pc_load_i,
    input  logic [ADDR_W-1:0] pc_load_val_i,
    input  logic              flush_i,
    input  logic              bus_ack_i,
    input  logic [7:0]        bus_rdata_i,
    input  logic              look_valid_i,
    input  logic [7:0]        rd_data_i,
    output logic [LINE_W-1:0] look_line_o,
    output logic [IDX_W-1:0]  rd_idx_o,
    output logic              fill_we_o,
    output logic [IDX_W-1:0]  fill_idx_o,
    output logic [7:0]        fill_data_o,
    output logic              vset_o,
    output logic [LINE_W-1:0] vset_line_o,
    output logic              vclr_o,
    output logic              busy_o,
    output logic              op_done_o,
    output logic [7:0]        op_byte_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic              pc_mod_o,
    output logic [COST_W-1:0] cost_o,
    output logic              bus_req_o,
    output logic [BUS_W-1:0]  bus_addr_o,
    output logic              rom_sync_o,
    output logic              ram_sync_o
);
    localparam logic [ADDR_W-1:0] WIN_LIMIT = ADDR_W'(WIN_BYTES);

    fetch_state_t          state_q;
    logic [ADDR_W-1:0]     pc_q;
    logic                  pc_mod_q;
    logic [7:0]            pref_q;
    logic [7:0]            op_byte_q;
    logic                  done_q;
    logic [COST_W-1:0]     cost_q;
    logic [IDX_W-1:0]      req_idx_q;
    logic [OFS_W-1:0]      fill_cnt_q;
    logic [BUS_W-1:0]      bus_base_q;
    logic                  ram_sel_q;
    logic                  flush_pend_q;

    logic [ADDR_W-1:0]     tgt;
    logic [ADDR_W-1:0]     tgt_ofs;
    logic [ADDR_W-1:0]     line_start;
    logic                  in_win;
    logic                  accept;
    logic                  xfer;
    logic                  fill_last;

    // Target address, window offset and the aligned source of its line.
    always_comb begin
        tgt        = op_adv_i ? pc_q + 1'b1 : pc_q;
        tgt_ofs    = tgt - base_i;
        in_win     = tgt_ofs < WIN_LIMIT;
        line_start = base_i + ADDR_W'({tgt_ofs[IDX_W-1:OFS_W], {OFS_W{1'b0}}});
        accept     = op_req_i && (state_q == ST_IDLE);
        xfer       = bus_req_o && bus_ack_i;
        fill_last  = (state_q == ST_FILL) && xfer && (fill_cnt_q == '1);
    end

    // Bus, store and valid-table controls.
    always_comb begin
        bus_req_o   = (state_q == ST_FILL) || (state_q == ST_DIRECT);
        bus_addr_o  = (state_q == ST_FILL) ? {bus_base_q[BUS_W-1:OFS_W], fill_cnt_q} : bus_base_q;
        look_line_o = tgt_ofs[IDX_W-1:OFS_W];
        rd_idx_o    = req_idx_q;
        fill_we_o   = (state_q == ST_FILL) && xfer;
        fill_idx_o  = {req_idx_q[IDX_W-1:OFS_W], fill_cnt_q};
        fill_data_o = bus_rdata_i;
        vset_o      = fill_last;
        vset_line_o = req_idx_q[IDX_W-1:OFS_W];
        vclr_o      = (flush_i && (state_q != ST_FILL)) || (fill_last && (flush_pend_q || flush_i));
        rom_sync_o  = (state_q == ST_SYNC) && !ram_sel_q;
        ram_sync_o  = (state_q == ST_SYNC) && ram_sel_q;
        busy_o      = (state_q != ST_IDLE);
        op_done_o   = done_q;
        op_byte_o   = op_byte_q;
        pc_o        = pc_q;
        pc_mod_o    = pc_mod_q;
        cost_o      = cost_q;
    end

    // Fetch sequencing: accept, fill, direct read and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            req_idx_q    <= '0;
            fill_cnt_q   <= '0;
            bus_base_q   <= '0;
            ram_sel_q    <= 1'b0;
            flush_pend_q <= 1'b0;
            pref_q       <= 8'h00;
            done_q       <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    req_idx_q <= tgt_ofs[IDX_W-1:0];
                    if (!in_win) begin
                        ram_sel_q  <= (bank_i > ROM_LAST_BANK);
                        bus_base_q <= {bank_i, tgt};
                        state_q    <= ST_SYNC;
                    end else if (look_valid_i) begin
                        state_q <= ST_READ;
                    end else begin
                        bus_base_q   <= {bank_i, line_start[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
                        fill_cnt_q   <= '0;
                        flush_pend_q <= 1'b0;
                        state_q      <= ST_FILL;
                    end
                end
                ST_READ: begin
                    pref_q  <= rd_data_i;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                ST_FILL: begin
                    if (flush_i) flush_pend_q <= 1'b1;
                    if (xfer) begin
                        fill_cnt_q <= fill_cnt_q + 1'b1;
                        if (fill_last) state_q <= ST_READ;
                    end
                end
                ST_SYNC: state_q <= ST_DIRECT;
                ST_DIRECT: if (xfer) begin
                    pref_q  <= bus_rdata_i;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Program counter, modified flag and returned opcode byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q      <= '0;
            pc_mod_q  <= 1'b0;
            op_byte_q <= 8'h00;
        end else if (accept) begin
            pc_q      <= tgt;
            pc_mod_q  <= 1'b0;
            op_byte_q <= pref_q;
        end else if (pc_load_i && !op_req_i && state_q == ST_IDLE) begin
            pc_q     <= pc_load_val_i;
            pc_mod_q <= 1'b1;
        end
    end

    // Cost accumulation: hit charge at accept, memory charge per bus byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                           cost_q <= '0;
        else if (xfer)                        cost_q <= cost_q + COST_W'(MEM_COST);
        else if (accept && in_win && look_valid_i) cost_q <= cost_q + COST_W'(CACHE_COST);
    end
endmodule

// File: rtl/ifetch_window_cache.sv
// Module: instruction fetch cache over a 512-byte window set by a base address.
// Joins the sequencer, the data store and the valid table, and arbitrates the host port.
// Assumes: host writes are wanted only while no fetch is in progress.
module ifetch_window_cache #(
    parameter int ADDR_W     = 16,
    parameter int BANK_W     = 8,
    parameter int LINE_BYTES = 16,
    parameter int NUM_LINES  = 32,
    parameter int COST_W     = 32,
    parameter int MEM_COST   = 5,
    parameter int CACHE_COST = 1,
    parameter logic [BANK_W-1:0] ROM_LAST_BANK = 8'h5F,
    localparam int WIN_BYTES = LINE_BYTES * NUM_LINES,
    localparam int OFS_W     = $clog2(LINE_BYTES),
    localparam int IDX_W     = $clog2(WIN_BYTES),
    localparam int LINE_W    = IDX_W - OFS_W,
    localparam int BUS_W     = BANK_W + ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic              op_req_i,
    input  logic              op_adv_i,
    input  logic              pc_load_i,
    input  logic [ADDR_W-1:0] pc_load_val_i,
    input  logic              flush_i,
    output logic              busy_o,
    output logic              op_done_o,
    output logic [7:0]        op_byte_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic              pc_mod_o,
    output logic [COST_W-1:0] cost_o,
    output logic              bus_req_o,
    output logic [BUS_W-1:0]  bus_addr_o,
    input  logic              bus_ack_i,
    input  logic [7:0]        bus_rdata_i,
    output logic              rom_sync_o,
    output logic              ram_sync_o,
    input  logic [IDX_W-1:0]  hst_addr_i,
    input  logic              hst_we_i,
    input  logic [7:0]        hst_wdata_i,
    output logic [7:0]        hst_rdata_o
);
    logic [LINE_W-1:0] look_line;
    logic              look_valid;
    logic [IDX_W-1:0]  rd_idx;
    logic [7:0]        rd_data;
    logic              fill_we;
    logic [IDX_W-1:0]  fill_idx;
    logic [7:0]        fill_data;
    logic              vset_fill;
    logic [LINE_W-1:0] vset_fill_line;
    logic              vclr;
    logic [IDX_W-1:0]  host_idx;
    logic              host_wr;
    logic              st_we;
    logic [IDX_W-1:0]  st_idx;
    logic [7:0]        st_data;
    logic              vset;
    logic [LINE_W-1:0] vset_line;

    // Host index relative to the base; arbitration of the store write and valid set.
    always_comb begin
        host_idx  = hst_addr_i + base_i[IDX_W-1:0];
        host_wr   = hst_we_i && !busy_o;
        st_we     = fill_we || host_wr;
        st_idx    = fill_we ? fill_idx  : host_idx;
        st_data   = fill_we ? fill_data : hst_wdata_i;
        vset      = vset_fill || (host_wr && (host_idx[OFS_W-1:0] == '1));
        vset_line = vset_fill ? vset_fill_line : host_idx[IDX_W-1:OFS_W];
    end

    ifc_fetch_ctrl #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W), .LINE_BYTES(LINE_BYTES),
        .WIN_BYTES(WIN_BYTES), .COST_W(COST_W), .MEM_COST(MEM_COST),
        .CACHE_COST(CACHE_COST), .ROM_LAST_BANK(ROM_LAST_BANK)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .base_i(base_i), .bank_i(bank_i),
        .op_req_i(op_req_i), .op_adv_i(op_adv_i), .pc_load_i(pc_load_i),
        .pc_load_val_i(pc_load_val_i), .flush_i(flush_i),
        .bus_ack_i(bus_ack_i), .bus_rdata_i(bus_rdata_i),
        .look_valid_i(look_valid), .rd_data_i(rd_data),
        .look_line_o(look_line), .rd_idx_o(rd_idx),
        .fill_we_o(fill_we), .fill_idx_o(fill_idx), .fill_data_o(fill_data),
        .vset_o(vset_fill), .vset_line_o(vset_fill_line), .vclr_o(vclr),
        .busy_o(busy_o), .op_done_o(op_done_o), .op_byte_o(op_byte_o),
        .pc_o(pc_o), .pc_mod_o(pc_mod_o), .cost_o(cost_o),
        .bus_req_o(bus_req_o), .bus_addr_o(bus_addr_o),
        .rom_sync_o(rom_sync_o), .ram_sync_o(ram_sync_o)
    );

    ifc_data_store #(.DEPTH(WIN_BYTES), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(st_we), .wr_idx(st_idx), .wr_data(st_data),
        .rd_idx(rd_idx), .rd_data(rd_data),
        .hrd_idx(host_idx), .hrd_data(hst_rdata_o)
    );

    ifc_valid_table #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_valid (
        .clk(clk), .rst_n(rst_n), .clr_all(vclr),
        .set_en(vset), .set_line(vset_line),
        .look_line(look_line), .look_valid(look_valid)
    );
endmodule

// File: rtl/ifc_checker.sv
// Module: protocol and timing properties of the window cache, attached by bind.
// Assumes: the default parameter set of the top module.
module ifc_checker #(
    parameter int ADDR_W    = 16,
    parameter int COST_W    = 32,
    parameter int MEM_COST  = 5,
    parameter int WIN_BYTES = 512
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_req_i,
    input logic              op_adv_i,
    input logic [ADDR_W-1:0] base_i,
    input logic              busy_o,
    input logic              op_done_o,
    input logic [ADDR_W-1:0] pc_o,
    input logic              pc_mod_o,
    input logic [COST_W-1:0] cost_o,
    input logic              bus_req_o,
    input logic              bus_ack_i,
    input logic              rom_sync_o,
    input logic              ram_sync_o
);
    logic [ADDR_W-1:0] chk_ofs;
    logic              chk_out;
    logic              chk_acc;

    // Window test seen from the ports at the moment of acceptance.
    always_comb begin
        chk_ofs = (op_adv_i ? pc_o + 1'b1 : pc_o) - base_i;
        chk_out = chk_ofs >= ADDR_W'(WIN_BYTES);
        chk_acc = op_req_i && !busy_o;
    end

    // R12
    busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ($stable(pc_o) && $stable(pc_mod_o)));
    // R12
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_done_o |=> !op_done_o);
    // R11
    mod_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_acc |=> !pc_mod_o);
    // R4
    cost_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && bus_ack_i) |=> (cost_o == $past(cost_o) + COST_W'(MEM_COST)));
    // R4
    cost_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(bus_req_o && bus_ack_i) && !chk_acc) |=> $stable(cost_o));
    // R1
    outside_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_acc && chk_out) |=> (rom_sync_o || ram_sync_o));
    // R1
    inside_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_acc && !chk_out) |=> !(rom_sync_o || ram_sync_o));
    // R5
    strobe_then_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_sync_o || ram_sync_o) |=> (bus_req_o && !rom_sync_o && !ram_sync_o));
    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rom_sync_o, ram_sync_o}));
    // R9
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (cost_o == '0 && !busy_o && !pc_mod_o));
endmodule

bind ifetch_window_cache ifc_checker #(
    .ADDR_W(ADDR_W), .COST_W(COST_W), .MEM_COST(MEM_COST), .WIN_BYTES(WIN_BYTES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .op_req_i(op_req_i), .op_adv_i(op_adv_i),
    .base_i(base_i), .busy_o(busy_o), .op_done_o(op_done_o), .pc_o(pc_o),
    .pc_mod_o(pc_mod_o), .cost_o(cost_o), .bus_req_o(bus_req_o),
    .bus_ack_i(bus_ack_i), .rom_sync_o(rom_sync_o), .ram_sync_o(ram_sync_o)
);

// File: tb/ifetch_window_cache_bench.sv
// Bench: directed scenarios for the window cache, one task each, with a bus memory model.
module ifetch_window_cache_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] base_i = '0;
    logic [7:0]  bank_i = '0;
    logic        op_req_i = 1'b0, op_adv_i = 1'b0, pc_load_i = 1'b0, flush_i = 1'b0;
    logic [15:0] pc_load_val_i = '0;
    logic        busy_o, op_done_o, pc_mod_o, bus_req_o, rom_sync_o, ram_sync_o;
    logic [7:0]  op_byte_o, hst_rdata_o;
    logic [15:0] pc_o;
    logic [31:0] cost_o;
    logic [23:0] bus_addr_o;
    logic        bus_ack_i = 1'b0;
    logic [7:0]  bus_rdata_i = '0;
    logic [8:0]  hst_addr_i = '0;
    logic        hst_we_i = 1'b0;
    logic [7:0]  hst_wdata_i = '0;

    int checks = 0, fails = 0;
    int xfers = 0, roms = 0, rams = 0;
    logic [23:0] first_addr, last_addr;
    logic [31:0] cost_before;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ifetch_window_cache u_ifetch_window_cache (.*);

    function automatic logic [7:0] mem_byte(input logic [23:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ (a[23:16] + 8'h35);
    endfunction

    // Bus model: acknowledge every request with the memory byte.
    always @(negedge clk) begin
        bus_ack_i   <= bus_req_o;
        bus_rdata_i <= mem_byte(bus_addr_o);
    end

    // Monitor of bus transfers and strobes.
    always @(posedge clk) if (rst_n) begin
        if (bus_req_o && bus_ack_i) begin
            if (xfers == 0) first_addr = bus_addr_o;
            last_addr = bus_addr_o;
            xfers++;
        end
        if (rom_sync_o) roms++;
        if (ram_sync_o) rams++;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    task automatic start_op(input bit adv);
        @(negedge clk);
        while (busy_o) @(negedge clk);
        xfers = 0; roms = 0; rams = 0;
        cost_before = cost_o;
        op_req_i = 1'b1; op_adv_i = adv;
        @(negedge clk);
        op_req_i = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!op_done_o && n < 200) begin @(negedge clk); n++; end
    endtask

    task automatic run_op(input bit adv);
        start_op(adv);
        wait_done();
    endtask

    task automatic load_pc(input logic [15:0] v);
        @(negedge clk); pc_load_i = 1'b1; pc_load_val_i = v;
        @(negedge clk); pc_load_i = 1'b0;
    endtask

    task automatic pulse_flush();
        @(negedge clk); flush_i = 1'b1;
        @(negedge clk); flush_i = 1'b0;
    endtask

    task automatic host_write(input logic [8:0] a, input logic [7:0] d);
        @(negedge clk); hst_we_i = 1'b1; hst_addr_i = a; hst_wdata_i = d;
        @(negedge clk); hst_we_i = 1'b0;
    endtask

    task automatic host_read(input logic [8:0] a, output logic [7:0] d);
        @(negedge clk); hst_addr_i = a;
        @(negedge clk); d = hst_rdata_o;
    endtask

    // R9: state after reset.
    task automatic t_reset();
        logic [7:0] d;
        check(pc_o == 16'h0 && !pc_mod_o, "R9 pc/flag after reset", pc_o, 0);
        check(cost_o == 0 && !busy_o, "R9 cost/busy after reset", cost_o, 0);
        check(op_byte_o == 8'h00, "R9 op_byte after reset", op_byte_o, 0);
        host_read(9'h000, d); check(d == 8'h00, "R9 byte 0 cleared", d, 0);
        host_read(9'h12C, d); check(d == 8'h00, "R9 byte 0x12C cleared", d, 0);
    endtask

    // R2, R3, R4, R10, R11: miss fill, then hits.
    task automatic t_fill_hit();
        base_i = 16'h1000; bank_i = 8'h02;
        load_pc(16'h1004);
        check(pc_mod_o && pc_o == 16'h1004, "R11 load sets flag", pc_o, 16'h1004);
        run_op(1'b0);
        check(xfers == 16, "R2 fill length", xfers, 16);
        check(first_addr == 24'h021000 && last_addr == 24'h02100F, "R2 fill addresses", first_addr, 24'h021000);
        check(cost_o - cost_before == 80, "R4 fill cost", cost_o - cost_before, 80);
        check(op_byte_o == 8'h00 && pc_o == 16'h1004, "R10 peek keeps pc", pc_o, 16'h1004);
        check(!pc_mod_o, "R11 fetch clears flag", pc_mod_o, 0);
        run_op(1'b1);
        check(xfers == 0, "R3 hit no bus", xfers, 0);
        check(cost_o - cost_before == 1, "R3 hit cost", cost_o - cost_before, 1);
        check(op_byte_o == mem_byte(24'h021004) && pc_o == 16'h1005, "R10 advance", op_byte_o, mem_byte(24'h021004));
        run_op(1'b0);
        check(op_byte_o == mem_byte(24'h021005) && pc_o == 16'h1005, "R10 prefetch at new pc", op_byte_o, mem_byte(24'h021005));
    endtask

    // R2: unaligned base gives an aligned source line.
    task automatic t_unaligned();
        pulse_flush();
        base_i = 16'h1003; bank_i = 8'h02;
        load_pc(16'h1024);
        run_op(1'b0);
        check(xfers == 16 && first_addr == 24'h021020, "R2 unaligned source", first_addr, 24'h021020);
        run_op(1'b1);
        check(op_byte_o == mem_byte(24'h021021), "R2 unaligned byte n=1", op_byte_o, mem_byte(24'h021021));
        run_op(1'b0);
        check(op_byte_o == mem_byte(24'h021022), "R2 unaligned byte n=2", op_byte_o, mem_byte(24'h021022));
    endtask

    // R1, R5: direct ROM and RAM reads, and the window edge.
    task automatic t_direct();
        base_i = 16'h1000; bank_i = 8'h5F;
        load_pc(16'h1200);
        run_op(1'b0);
        check(roms == 1 && rams == 0, "R5 rom strobe", roms, 1);
        check(xfers == 1 && first_addr == 24'h5F1200, "R5 direct address", first_addr, 24'h5F1200);
        check(cost_o - cost_before == 5, "R4 direct cost", cost_o - cost_before, 5);
        run_op(1'b0);
        check(op_byte_o == mem_byte(24'h5F1200), "R5 direct byte", op_byte_o, mem_byte(24'h5F1200));
        load_pc(16'h11FF);
        run_op(1'b0);
        check(roms == 0 && xfers == 16 && first_addr == 24'h5F11F0, "R1 offset 511 in window", first_addr, 24'h5F11F0);
        bank_i = 8'h60;
        load_pc(16'h0FFF);
        run_op(1'b0);
        check(rams == 1 && roms == 0 && first_addr == 24'h600FFF, "R5 ram strobe", first_addr, 24'h600FFF);
        run_op(1'b0);
        check(op_byte_o == mem_byte(24'h600FFF), "R5 ram byte", op_byte_o, mem_byte(24'h600FFF));
    endtask

    // R6: flush keeps data and forces a refill.
    task automatic t_flush();
        logic [7:0] d;
        base_i = 16'h1000; bank_i = 8'h5F;
        host_read(9'h1FF, d);
        check(d == mem_byte(24'h5F11FF), "R8 host read of filled byte", d, mem_byte(24'h5F11FF));
        pulse_flush();
        host_read(9'h1FF, d);
        check(d == mem_byte(24'h5F11FF), "R6 data kept after flush", d, mem_byte(24'h5F11FF));
        load_pc(16'h11FE);
        run_op(1'b0);
        check(xfers == 16, "R6 refill after flush", xfers, 16);
        run_op(1'b0);
        check(xfers == 0 && op_byte_o == mem_byte(24'h5F11FE), "R3 hit after refill", op_byte_o, mem_byte(24'h5F11FE));
    endtask

    // R7: flush during a fill.
    task automatic t_flush_mid_fill();
        base_i = 16'h1000; bank_i = 8'h03;
        load_pc(16'h1050);
        start_op(1'b0);
        repeat (4) @(negedge clk);
        flush_i = 1'b1; @(negedge clk); flush_i = 1'b0;
        wait_done();
        check(xfers == 16, "R7 fill completes", xfers, 16);
        run_op(1'b0);
        check(xfers == 16, "R7 line left invalid", xfers, 16);
        check(op_byte_o == mem_byte(24'h031050), "R7 byte delivered", op_byte_o, mem_byte(24'h031050));
    endtask

    // R8: host port indexing, line validation, writes ignored while busy.
    task automatic t_host();
        logic [7:0] d;
        base_i = 16'h0100; bank_i = 8'h04;
        for (int n = 0; n < 16; n++) host_write(9'h140 + 9'(n), 8'hA0 + 8'(n));
        load_pc(16'h0143);
        run_op(1'b0);
        check(xfers == 0, "R8 host line valid", xfers, 0);
        run_op(1'b0);
        check(op_byte_o == 8'hA3, "R8 host byte fetched", op_byte_o, 8'hA3);
        host_read(9'h141, d);
        check(d == 8'hA1, "R8 host read index", d, 8'hA1);
        pulse_flush();
        host_write(9'h150, 8'h77);
        load_pc(16'h0150);
        start_op(1'b0);
        repeat (3) @(negedge clk);
        hst_we_i = 1'b1; hst_addr_i = 9'h145; hst_wdata_i = 8'hEE;
        @(negedge clk); hst_we_i = 1'b0;
        wait_done();
        check(xfers == 16 && first_addr == 24'h040150, "R8 partial line not valid", first_addr, 24'h040150);
        host_read(9'h145, d);
        check(d == 8'hA5, "R8 write while busy ignored", d, 8'hA5);
        run_op(1'b0);
        check(op_byte_o == mem_byte(24'h040150), "R8 fill overwrote host byte", op_byte_o, mem_byte(24'h040150));
    endtask

    // R12, R11: requests and loads during a fill are ignored.
    task automatic t_busy();
        pulse_flush();
        base_i = 16'h1000; bank_i = 8'h06;
        load_pc(16'h1080);
        start_op(1'b0);
        repeat (2) @(negedge clk);
        check(busy_o, "R12 busy during fill", busy_o, 1);
        op_req_i = 1'b1; op_adv_i = 1'b1; pc_load_i = 1'b1; pc_load_val_i = 16'h2222;
        @(negedge clk);
        op_req_i = 1'b0; pc_load_i = 1'b0;
        wait_done();
        check(op_done_o && !busy_o, "R12 done with busy low", op_done_o, 1);
        check(pc_o == 16'h1080 && !pc_mod_o, "R11 R12 busy inputs ignored", pc_o, 16'h1080);
        @(negedge clk);
        check(!op_done_o, "R12 done is one cycle", op_done_o, 0);
        check(xfers == 16, "R12 single fill", xfers, 16);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill_hit();
        t_unaligned();
        t_direct();
        t_flush();
        t_flush_mid_fill();
        t_host();
        t_busy();
        report();
    end
endmodule